// File: doc/BRIEF.md
# Interrupt Priority Resolver

The resolver chooses one interrupt line to report for each of two interrupt classes, the normal class (IRQ) and the fast class (FIQ). Each line carries a pending bit, a mask bit, a class-select bit and a priority code. Lines come in banks of 32, and there are one to three banks. From these inputs a registered comparison tree finds the best eligible line for each class. A small agreement controller per class then decides when that winner is latched and signalled to the processor.

Each class has an agreement flag. While the flag is armed, the first cycle that has a winner and the global enable set latches the winner's code, raises the class request and disarms the flag. From then on the code and the request are frozen, whatever the inputs do. The interrupt handler acknowledges with a one-cycle rearm pulse. The pulse drops the request and arms the flag again, so the next winner can be taken. Register decoding and input edge or level sensing belong to neighbouring logic.

Top module: `irq_prio_resolver`

## Requirements
- R1: A line is eligible for a class when its pending bit is 1, its mask bit is 0, and its class-select bit equals the class (1 selects FIQ, 0 selects IRQ). Masked lines, and lines of the other class, never win.
- R2: Among eligible lines, the smallest priority value wins. Value 0 is the most urgent.
- R3: When several eligible lines share the smallest priority value, the line with the highest number wins.
- R4: The reported code is 32 × bank + bit, which is the flat index of the line in the input vectors.
- R5: A class captures only in a cycle where three things hold: its flag is armed, the registered resolver has a winner, and global_en_i is 1. A capture latches the code, drives the class request high and disarms the flag.
- R6: While a class is disarmed, its code and its request keep their values, whatever the pending, mask, class, priority and enable inputs do.
- R7: A rearm pulse for a class drives that class's request low on the next edge and arms its flag. A capture can follow on a later edge.
- R8: The IRQ and FIQ classes have separate flags, codes and requests. Rearming or capturing one class leaves the other class unchanged.
- R9: After reset, both flags are armed, both codes are 0 and both requests are low.
- R10: An armed class with global enable on raises its request at the second rising edge after an eligible line appears. The first edge loads the resolver register and the second edge captures. If the resolver register already holds a winner when the enable turns on, the capture happens at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_i | input | NUM_BANKS*32 | Per-line pending bits |
| mask_i | input | NUM_BANKS*32 | Per-line mask bits, 1 = masked |
| fiq_sel_i | input | NUM_BANKS*32 | Per-line class select, 1 = FIQ, 0 = IRQ |
| prio_i | input | NUM_BANKS*32*PRIO_W | Priority code of line n in bits [n*PRIO_W +: PRIO_W] |
| global_en_i | input | 1 | Global enable for captures |
| rearm_irq_i | input | 1 | One-cycle rearm of the IRQ class |
| rearm_fiq_i | input | 1 | One-cycle rearm of the FIQ class |
| irq_req_o | output | 1 | IRQ request, high while a captured IRQ winner is held |
| irq_code_o | output | CODE_W | Captured IRQ line code |
| fiq_req_o | output | 1 | FIQ request, high while a captured FIQ winner is held |
| fiq_code_o | output | CODE_W | Captured FIQ line code |

## Verification
The bench uses two banks and 5-bit priorities. It drives one eligible line at a time through all 64 positions in both classes, which shows the code formula for both banks and confirms that masked lines and lines of the other class are ignored. Fully pending vectors with one shared priority, swept over all 32 values, show the highest-number tie rule. A single urgent line placed among lower-urgency lines shows that priority beats position. Random vectors with narrow priority ranges compare both classes against an arithmetic model. Directed sequences then count edges to capture, toggle the global enable, change inputs while a class is disarmed and rearm one class at a time, which separates the latency, gating, hold and independence rules.

// File: rtl/irq_res_pkg.sv
// Package: shared constants and helpers for the interrupt priority resolver.
// Assumes: lines come in banks of a fixed size of 32.
package irq_res_pkg;

    localparam int unsigned LINES_PER_BANK = 32;

    typedef enum logic {
        CLS_IRQ = 1'b0,
        CLS_FIQ = 1'b1
    } irq_class_e;

    // Tie-break rule for one tree node: the right (higher-numbered) child wins on equal priority.
    function automatic logic right_beats_left(input logic l_vld, input logic r_vld,
                                              input int unsigned l_prio, input int unsigned r_prio);
        return r_vld && (!l_vld || (r_prio <= l_prio));
    endfunction

endpackage

// File: rtl/irq_cand_filter.sv
// Module: irq_cand_filter
// Works out, for every line, whether it is eligible in the IRQ class and in the FIQ class.
// Assumes: mask bit 1 blocks a line; class bit 1 selects FIQ.
module irq_cand_filter #(
    parameter int unsigned NLINES = 96
) (
    input  logic [NLINES-1:0] pend_i,
    input  logic [NLINES-1:0] mask_i,
    input  logic [NLINES-1:0] fiq_sel_i,
    output logic [NLINES-1:0] cand_irq_o,
    output logic [NLINES-1:0] cand_fiq_o
);

    // Purpose: split the unmasked pending lines by class.
    always_comb begin
        cand_irq_o = pend_i & ~mask_i & ~fiq_sel_i;
        cand_fiq_o = pend_i & ~mask_i &  fiq_sel_i;
    end

endmodule

// File: rtl/irq_prio_tree.sv
// Module: irq_prio_tree
// A binary comparison tree that picks the eligible line with the smallest priority,
// with ties going to the higher line number. The result is registered once at the root.
// Assumes: the leaves are padded up to a power of two with invalid entries.
module irq_prio_tree
    import irq_res_pkg::*;
#(
    parameter int unsigned NLINES = 96,
    parameter int unsigned PRIO_W = 6,
    localparam int unsigned CODE_W = $clog2(NLINES),
    localparam int unsigned LEAVES = 1 << CODE_W,
    localparam int unsigned NODES  = 2 * LEAVES - 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NLINES-1:0]        cand_i,
    input  logic [NLINES*PRIO_W-1:0] prio_i,
    output logic                     win_vld_o,
    output logic [CODE_W-1:0]        win_code_o
);

    logic              n_vld  [NODES];
    logic [PRIO_W-1:0] n_prio [NODES];
    logic [CODE_W-1:0] n_idx  [NODES];

    // Leaves: real lines carry their inputs, padding leaves are never valid.
    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < NLINES) begin : g_real
            assign n_vld[LEAVES-1+i]  = cand_i[i];
            assign n_prio[LEAVES-1+i] = prio_i[i*PRIO_W +: PRIO_W];
        end else begin : g_pad
            assign n_vld[LEAVES-1+i]  = 1'b0;
            assign n_prio[LEAVES-1+i] = '1;
        end
        assign n_idx[LEAVES-1+i] = CODE_W'(i);
    end

    // Inner nodes: each one keeps the better of its lower-index and higher-index child.
    for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
        logic take_r;
        assign take_r    = right_beats_left(n_vld[2*n+1], n_vld[2*n+2],
                                            int'(n_prio[2*n+1]), int'(n_prio[2*n+2]));
        assign n_vld[n]  = n_vld[2*n+1] | n_vld[2*n+2];
        assign n_prio[n] = take_r ? n_prio[2*n+2] : n_prio[2*n+1];
        assign n_idx[n]  = take_r ? n_idx[2*n+2]  : n_idx[2*n+1];
    end

    // Purpose: register the root result; the code reads 0 when there is no winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_vld_o  <= 1'b0;
            win_code_o <= '0;
        end else begin
            win_vld_o  <= n_vld[0];
            win_code_o <= n_vld[0] ? n_idx[0] : '0;
        end
    end

    // R1: with no eligible line in the previous cycle there is no winner now.
    a_r1_empty_no_win: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cand_i) == '0) |-> !win_vld_o);

    // R1: a registered winner was an eligible line in the previous cycle.
    a_r1_win_is_cand: assert property (@(posedge clk) disable iff (!rst_n)
        win_vld_o |-> (($past(cand_i) >> win_code_o) & NLINES'(1)) != '0);

endmodule

// File: rtl/irq_agree_ctrl.sv
// Module: irq_agree_ctrl
// Agreement handshake for one class: it latches the resolver result once per rearm
// and holds the request and the code until the next rearm.
// Assumes: rearm_i is a one-cycle pulse; if it meets a capture condition, the rearm wins.
module irq_agree_ctrl #(
    parameter int unsigned CODE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_vld_i,
    input  logic [CODE_W-1:0] win_code_i,
    input  logic              global_en_i,
    input  logic              rearm_i,
    output logic              req_o,
    output logic [CODE_W-1:0] code_o
);

    logic armed_q;
    logic take;

    // Purpose: the capture condition of the handshake.
    always_comb take = armed_q && win_vld_i && global_en_i;

    // Purpose: arm, capture and hold state of one class.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b1;
            req_o   <= 1'b0;
            code_o  <= '0;
        end else if (rearm_i) begin
            armed_q <= 1'b1;
            req_o   <= 1'b0;
        end else if (take) begin
            armed_q <= 1'b0;
            req_o   <= 1'b1;
            code_o  <= win_code_i;
        end
    end

    // R5: a capture disarms the class, raises the request and takes the winner's code.
    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && win_vld_i && global_en_i && !rearm_i) |=>
            (!armed_q && req_o && code_o == $past(win_code_i)));

    // R5: an armed class never shows a raised request.
    a_r5_arm_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(armed_q && req_o));

    // R6: a disarmed class holds its code and request until a rearm.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !rearm_i) |=> ($stable(code_o) && $stable(req_o)));

    // R7: a rearm drops the request and arms the class.
    a_r7_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_i |=> (armed_q && !req_o));

endmodule

// File: rtl/irq_prio_resolver.sv
// Module: irq_prio_resolver (top)
// Resolves the winning IRQ line and FIQ line across NUM_BANKS banks of 32 lines,
// and runs a separate agreement handshake for each class.
// Assumes: inputs are synchronous to clk; NUM_BANKS is 1..3; PRIO_W is 5 or 6.
module irq_prio_resolver
    import irq_res_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 3,
    parameter int unsigned PRIO_W    = 6,
    localparam int unsigned NLINES   = NUM_BANKS * LINES_PER_BANK,
    localparam int unsigned CODE_W   = $clog2(NLINES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NLINES-1:0]        pend_i,
    input  logic [NLINES-1:0]        mask_i,
    input  logic [NLINES-1:0]        fiq_sel_i,
    input  logic [NLINES*PRIO_W-1:0] prio_i,
    input  logic                     global_en_i,
    input  logic                     rearm_irq_i,
    input  logic                     rearm_fiq_i,
    output logic                     irq_req_o,
    output logic [CODE_W-1:0]        irq_code_o,
    output logic                     fiq_req_o,
    output logic [CODE_W-1:0]        fiq_code_o
);

    logic [NLINES-1:0] cand [2];
    logic              win_vld  [2];
    logic [CODE_W-1:0] win_code [2];
    logic              rearm    [2];
    logic              req      [2];
    logic [CODE_W-1:0] code     [2];

    irq_cand_filter #(.NLINES(NLINES)) u_filter (
        .pend_i     (pend_i),
        .mask_i     (mask_i),
        .fiq_sel_i  (fiq_sel_i),
        .cand_irq_o (cand[CLS_IRQ]),
        .cand_fiq_o (cand[CLS_FIQ])
    );

    assign rearm[CLS_IRQ] = rearm_irq_i;
    assign rearm[CLS_FIQ] = rearm_fiq_i;

    // One resolver tree and one handshake per class.
    for (genvar c = 0; c < 2; c++) begin : g_cls
        irq_prio_tree #(.NLINES(NLINES), .PRIO_W(PRIO_W)) u_tree (
            .clk        (clk),
            .rst_n      (rst_n),
            .cand_i     (cand[c]),
            .prio_i     (prio_i),
            .win_vld_o  (win_vld[c]),
            .win_code_o (win_code[c])
        );

        irq_agree_ctrl #(.CODE_W(CODE_W)) u_agree (
            .clk         (clk),
            .rst_n       (rst_n),
            .win_vld_i   (win_vld[c]),
            .win_code_i  (win_code[c]),
            .global_en_i (global_en_i),
            .rearm_i     (rearm[c]),
            .req_o       (req[c]),
            .code_o      (code[c])
        );
    end

    assign irq_req_o  = req[CLS_IRQ];
    assign irq_code_o = code[CLS_IRQ];
    assign fiq_req_o  = req[CLS_FIQ];
    assign fiq_code_o = code[CLS_FIQ];

    // R8: rearming only FIQ leaves the IRQ outputs untouched on the next edge, if IRQ is held.
    a_r8_irq_indep: assert property (@(posedge clk) disable iff (!rst_n)
        (rearm_fiq_i && !rearm_irq_i && irq_req_o) |=> ($stable(irq_code_o) && irq_req_o));

endmodule

// File: tb/irq_prio_resolver_tb_top.sv
// Bench: sweeps a two-bank, 5-bit-priority resolver and checks it against an arithmetic model.
module irq_prio_resolver_tb_top;

    localparam int NB = 2;
    localparam int PW = 5;
    localparam int NL = NB * 32;
    localparam int CW = $clog2(NL);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NL-1:0]    pend = '0, mask = '0, fsel = '0;
    logic [NL*PW-1:0] prio = '0;
    logic glob = 1'b1, rarm_i = 1'b0, rarm_f = 1'b0;
    logic irq_req, fiq_req;
    logic [CW-1:0] irq_code, fiq_code;

    int n_chk = 0;
    int n_bad = 0;
    int exp_ic = 0;
    int exp_fc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_prio_resolver #(.NUM_BANKS(NB), .PRIO_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .mask_i(mask), .fiq_sel_i(fsel),
        .prio_i(prio), .global_en_i(glob), .rearm_irq_i(rarm_i), .rearm_fiq_i(rarm_f),
        .irq_req_o(irq_req), .irq_code_o(irq_code), .fiq_req_o(fiq_req), .fiq_code_o(fiq_code)
    );

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // Model: scan lines in ascending order; "<=" lets a later line win ties.
    function automatic int model(input bit cls, output bit found);
        int best = 0;
        int code = 0;
        found = 1'b0;
        for (int l = 0; l < NL; l++) begin
            if (pend[l] && !mask[l] && (fsel[l] == cls)) begin
                int p = int'(prio[l*PW +: PW]);
                if (!found || p <= best) begin
                    best = p;
                    code = l;
                    found = 1'b1;
                end
            end
        end
        return code;
    endfunction

    // Rearms the selected classes with the current inputs, waits for capture, checks.
    task automatic capture(input bit di, input bit df, input string rq);
        bit fi, ff;
        int ci, cf;
        ci = model(1'b0, fi);
        cf = model(1'b1, ff);
        rarm_i = di;
        rarm_f = df;
        @(negedge clk);
        rarm_i = 1'b0;
        rarm_f = 1'b0;
        @(negedge clk);
        if (di) begin
            if (fi) exp_ic = ci;
            chk({rq, " irq req"}, int'(irq_req), int'(fi));
            chk({rq, " irq code"}, int'(irq_code), exp_ic);
        end
        if (df) begin
            if (ff) exp_fc = cf;
            chk({rq, " fiq req"}, int'(fiq_req), int'(ff));
            chk({rq, " fiq code"}, int'(fiq_code), exp_fc);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk("R9 irq req", int'(irq_req), 0);
        chk("R9 fiq req", int'(fiq_req), 0);
        chk("R9 irq code", int'(irq_code), 0);
        chk("R9 fiq code", int'(fiq_code), 0);

        // R1 R4: one line at a time, every position, both classes, plus a masked copy.
        for (int l = 0; l < NL; l++) begin
            for (int c = 0; c < 2; c++) begin
                pend = '0; mask = '0; fsel = '0;
                pend[l] = 1'b1;
                fsel[l] = c[0];
                prio[l*PW +: PW] = PW'(l % 32);
                capture(1'b1, 1'b1, "R4 single line");
                mask[l] = 1'b1;
                capture(c == 0, c == 1, "R1 masked line");
            end
        end

        // R3: all lines pending with one shared priority; odd lines are FIQ.
        for (int v = 0; v < 32; v++) begin
            pend = '1; mask = '0;
            for (int l = 0; l < NL; l++) begin
                fsel[l] = l[0];
                prio[l*PW +: PW] = PW'(v);
            end
            capture(1'b1, 1'b1, "R3 tie");
        end

        // R2: one urgent line among lower-urgency ones.
        for (int l = 0; l < NL; l++) prio[l*PW +: PW] = 5'd1;
        prio[5*PW +: PW] = 5'd0;
        prio[10*PW +: PW] = 5'd0;
        capture(1'b1, 1'b1, "R2 urgent line");

        // R2 R8: random vectors with narrow priority ranges, both classes together.
        for (int k = 0; k < 400; k++) begin
            pend = {$urandom, $urandom};
            mask = {$urandom, $urandom} & {$urandom, $urandom};
            fsel = {$urandom, $urandom};
            for (int l = 0; l < NL; l++) prio[l*PW +: PW] = PW'($urandom % ((k % 4) * 8 + 2));
            capture(1'b1, 1'b1, "R2 random");
        end

        // R10: latency of two edges from a new eligible line to the request.
        pend = '0; mask = '0; fsel = '0;
        for (int l = 0; l < NL; l++) prio[l*PW +: PW] = 5'd3;
        capture(1'b1, 1'b1, "R10 empty rearm");
        pend[7] = 1'b1;
        @(negedge clk);
        chk("R10 after one edge", int'(irq_req), 0);
        @(negedge clk);
        chk("R10 after two edges req", int'(irq_req), 1);
        chk("R10 after two edges code", int'(irq_code), 7);
        exp_ic = 7;

        // R6: inputs change while IRQ is disarmed.
        pend = '0; pend[9] = 1'b1; prio[9*PW +: PW] = 5'd0;
        glob = 1'b0;
        repeat (4) @(negedge clk);
        glob = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6 hold code", int'(irq_code), 7);
        chk("R6 hold req", int'(irq_req), 1);

        // R8: a FIQ capture does not touch the held IRQ result.
        pend[33] = 1'b1; fsel[33] = 1'b1;
        capture(1'b0, 1'b1, "R8 fiq capture");
        chk("R8 irq code kept", int'(irq_code), 7);
        chk("R8 irq req kept", int'(irq_req), 1);

        // R5 R7: a rearm with the enable off drops the request and blocks a capture.
        pend = '0; pend[40] = 1'b1;
        @(negedge clk);
        glob = 1'b0;
        rarm_i = 1'b1;
        @(negedge clk);
        rarm_i = 1'b0;
        chk("R7 rearm drops req", int'(irq_req), 0);
        repeat (4) @(negedge clk);
        chk("R5 enable off req", int'(irq_req), 0);
        chk("R5 enable off code", int'(irq_code), 7);
        glob = 1'b1;
        @(negedge clk);
        chk("R10 enable on req", int'(irq_req), 1);
        chk("R5 enable on code", int'(irq_code), 40);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule